// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block sits beside the command scheduler of one DRAM rank and decides when the rank's clock enable (CKE) may drop. Three inputs drive it: whether the scheduler holds any access for the rank, whether any bank of the rank has a row open, and a policy bit. Whenever the rank is in standby with no access waiting, the controller starts power-down entry on the next clock. It picks active power-down if a bank is open. If every bank is precharged, it picks precharge power-down, fast or slow according to the policy bit.

When an access shows up, the controller raises CKE and holds `ready` low for the exit latency of the mode being left. Slow precharge power-down needs the longest wait, because its delay-locked loop has to relock. `ready` then rises and the scheduler may issue commands. A request that arrives while entry is still under way waits until entry has run its full length, and the exit then follows straight away.

The controller also keeps one saturating counter per power mode, counting the clock cycles spent in that mode. A select port reads these counters out. The mode encoding reserves two codes for self-refresh, but this controller never enters them.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: While reset is held: `cke`=1, `ready`=1, `pwr_mode`=1 (precharge standby), and every residency counter reads 0.
- R2: In standby, `pwr_mode` follows `bank_open` one cycle later: code 0 (active standby) when it is 1, code 1 (precharge standby) when it is 0. It takes that value again in the same cycle that `ready` returns after an exit.
- R3: If `req_pending` is 0 at a clock edge while the rank is in standby with `ready`=1, then `cke` and `ready` are both 0 from that edge on.
- R4: The mode chosen at entry depends on `bank_open` and `pd_slow` at the entry edge. `bank_open`=1 gives code 2 (active power-down). `bank_open`=0 with `pd_slow`=0 gives code 3 (precharge power-down fast). `bank_open`=0 with `pd_slow`=1 gives code 4 (precharge power-down slow). `pwr_mode` keeps the chosen value for as long as `cke` stays 0.
- R5: Entry keeps `cke` at 0 for at least ENTRY_CYC cycles (default 2). If `req_pending` is 1 again during entry, `cke` rises exactly ENTRY_CYC cycles after it fell.
- R6: When `req_pending` is 1 at an edge in power-down, `cke` is 1 from that edge. `ready` then stays 0 for LAT_APD (4), LAT_PPDF (4) or LAT_PPDS (6) cycles, matching mode 2, 3 or 4, before it returns to 1. `ready`=1 never occurs with `cke`=0.
- R7: With `res_sel`=m, `res_count` equals the number of clock edges since reset at which `pwr_mode` was m, saturating at all ones. A `res_sel` value of 7 reads 0.
- R8: `pwr_mode` never takes code 5 or 6 (self-refresh fast or slow), and the counters for those codes read 0.
- R9: While `ready`=1 and `req_pending`=1, the rank stays in standby: `ready` and `cke` stay 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_pending | input | 1 | The scheduler holds at least one access for this rank |
| bank_open | input | 1 | At least one bank of the rank has an open row |
| pd_slow | input | 1 | Policy for precharge power-down: 1 selects slow, 0 selects fast |
| cke | output | 1 | Clock enable to the rank |
| ready | output | 1 | The rank may accept commands |
| pwr_mode | output | 3 | Current power mode code (0 to 6) |
| res_sel | input | 3 | Selects the mode whose residency counter is read |
| res_count | output | CNT_W | Residency count for the selected mode |

## Verification
The assertions assume that `bank_open` stays steady from power-down entry until `ready` returns. Without that, the standby mode after an exit could not be predicted. They also assume `req_pending` is a clean level that only changes between clock edges. The bench drives every input shortly after a rising edge and keeps `bank_open` and `pd_slow` fixed through each entry and exit cycle. It sweeps every combination of bank state, policy bit, and request arrival (during entry, or after idle power-down cycles).

// File: rtl/rpc_pkg.sv
// Shared types for the rank power-down controller.
// Assumes a 3-bit mode code; the codes are visible on the top-level ports.
package rpc_pkg;

    typedef enum logic [2:0] {
        M_ACT_STBY  = 3'd0,
        M_PRE_STBY  = 3'd1,
        M_ACT_PDN   = 3'd2,
        M_PRE_PDN_F = 3'd3,
        M_PRE_PDN_S = 3'd4,
        M_SREF_F    = 3'd5,
        M_SREF_S    = 3'd6
    } pmode_t;

    typedef enum logic [1:0] {
        PH_STBY  = 2'd0,
        PH_ENTER = 2'd1,
        PH_PDN   = 2'd2,
        PH_EXIT  = 2'd3
    } phase_t;

    localparam int NUM_MODES = 7;
    localparam int MODE_W    = 3;

endpackage

// File: rtl/pwr_exit_lut.sv
// Maps a power mode to the number of cycles CKE must be high before
// commands are allowed again. Assumes every width fits in LW bits;
// standby codes return 1 so a caller never loads a zero-length wait.
module pwr_exit_lut
    import rpc_pkg::*;
#(
    parameter int LAT_APD  = 4,
    parameter int LAT_PPDF = 4,
    parameter int LAT_PPDS = 6,
    parameter int LW       = 3
) (
    input  pmode_t          mode,
    output logic [LW-1:0]   lat
);

    // Purpose: pick the exit wait for the given mode.
    always_comb begin
        case (mode)
            M_ACT_PDN:   lat = LW'(LAT_APD);
            M_PRE_PDN_F: lat = LW'(LAT_PPDF);
            M_PRE_PDN_S: lat = LW'(LAT_PPDS);
            default:     lat = LW'(1);
        endcase
    end

endmodule

// File: rtl/pwr_state_fsm.sv
// Phase sequencer for one rank: standby, power-down entry, power-down and
// exit. Drives CKE and ready and reports the current power mode.
// Assumes ENTRY_CYC >= 1, and that bank_open stays steady from entry until
// ready returns.
module pwr_state_fsm
    import rpc_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int LAT_APD   = 4,
    parameter int LAT_PPDF  = 4,
    parameter int LAT_PPDS  = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_pending,
    input  logic   bank_open,
    input  logic   pd_slow,
    output logic   cke,
    output logic   ready,
    output pmode_t mode
);

    localparam int MAX_A = (LAT_APD > LAT_PPDF) ? LAT_APD : LAT_PPDF;
    localparam int MAX_B = (MAX_A > LAT_PPDS) ? MAX_A : LAT_PPDS;
    localparam int MAX_L = (MAX_B > ENTRY_CYC) ? MAX_B : ENTRY_CYC;
    localparam int TW    = $clog2(MAX_L + 1);

    phase_t          phase_q;
    pmode_t          mode_q;
    logic [TW-1:0]   tmr_q;
    logic [TW-1:0]   lat;
    pmode_t          stby_mode;
    pmode_t          pdn_pick;

    // Purpose: exit wait of the mode currently held.
    pwr_exit_lut #(
        .LAT_APD (LAT_APD),
        .LAT_PPDF(LAT_PPDF),
        .LAT_PPDS(LAT_PPDS),
        .LW      (TW)
    ) u_lat (
        .mode(mode_q),
        .lat (lat)
    );

    // Purpose: standby flavour and power-down target from bank state and policy.
    always_comb begin
        stby_mode = bank_open ? M_ACT_STBY : M_PRE_STBY;
        if (bank_open)    pdn_pick = M_ACT_PDN;
        else if (pd_slow) pdn_pick = M_PRE_PDN_S;
        else              pdn_pick = M_PRE_PDN_F;
    end

    // Purpose: advance the phase, the reported mode and the wait timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STBY;
            mode_q  <= M_PRE_STBY;
            tmr_q   <= '0;
        end else begin
            case (phase_q)
                PH_STBY: begin
                    if (!req_pending) begin
                        phase_q <= PH_ENTER;
                        mode_q  <= pdn_pick;
                        tmr_q   <= TW'(ENTRY_CYC - 1);
                    end else begin
                        mode_q  <= stby_mode;
                    end
                end
                PH_ENTER: begin
                    if (tmr_q == '0) begin
                        if (req_pending) begin
                            phase_q <= PH_EXIT;
                            tmr_q   <= lat - TW'(1);
                        end else begin
                            phase_q <= PH_PDN;
                        end
                    end else begin
                        tmr_q <= tmr_q - TW'(1);
                    end
                end
                PH_PDN: begin
                    if (req_pending) begin
                        phase_q <= PH_EXIT;
                        tmr_q   <= lat - TW'(1);
                    end
                end
                default: begin
                    if (tmr_q == '0) begin
                        phase_q <= PH_STBY;
                        mode_q  <= stby_mode;
                    end else begin
                        tmr_q <= tmr_q - TW'(1);
                    end
                end
            endcase
        end
    end

    assign cke   = (phase_q == PH_STBY) || (phase_q == PH_EXIT);
    assign ready = (phase_q == PH_STBY);
    assign mode  = mode_q;

    // ---------------- checks ----------------
    // Counts cycles with CKE high and ready low, plus the mode of the
    // previous cycle, to compare each exit against its mode's wait.
    logic [TW:0]   hi_wait_q;
    pmode_t        prev_mode_q;
    logic [TW-1:0] prev_lat;

    // Purpose: measure each exit window from the port-level signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_wait_q   <= '0;
            prev_mode_q <= M_PRE_STBY;
        end else begin
            prev_mode_q <= mode_q;
            if (ready)    hi_wait_q <= '0;
            else if (cke) hi_wait_q <= hi_wait_q + 1'b1;
        end
    end

    pwr_exit_lut #(
        .LAT_APD (LAT_APD),
        .LAT_PPDF(LAT_PPDF),
        .LAT_PPDS(LAT_PPDS),
        .LW      (TW)
    ) u_chk_lat (
        .mode(prev_mode_q),
        .lat (prev_lat)
    );

    AST_ENTRY_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!$past(req_pending) && $past(ready))); // R3
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$past(cke)) |-> $stable(mode_q)); // R4
    AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cke); // R6
    AST_EXIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (hi_wait_q == {1'b0, prev_lat})); // R6
    AST_STAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_pending) |=> (ready && cke)); // R9

endmodule

// File: rtl/pwr_residency.sv
// One saturating cycle counter per mode code, plus a read mux.
// Assumes the mode input is registered; the unused code 7 reads zero.
module pwr_residency
    import rpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pmode_t            mode,
    input  logic [MODE_W-1:0] sel,
    output logic [CNT_W-1:0]  count
);

    localparam int SLOTS = 2 ** MODE_W;

    logic [CNT_W-1:0] cnt [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_MODES) begin : g_live
            logic [CNT_W-1:0] c_q;
            // Purpose: count cycles spent in mode g, stopping at all ones.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    c_q <= '0;
                else if ((mode == pmode_t'(g)) && (c_q != {CNT_W{1'b1}}))
                    c_q <= c_q + 1'b1;
            end
            assign cnt[g] = c_q;
        end else begin : g_none
            assign cnt[g] = '0;
        end
    end

    assign count = cnt[sel];

    AST_NO_SELF_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[M_SREF_F] == '0) && (cnt[M_SREF_S] == '0)); // R8

endmodule

// File: rtl/rank_pwr_ctrl.sv
// Top of the rank power-down controller: the phase sequencer plus the
// residency counters. Assumes a single clock and a synchronous active-low reset.
module rank_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int LAT_APD   = 4,
    parameter int LAT_PPDF  = 4,
    parameter int LAT_PPDS  = 6,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pending,
    input  logic             bank_open,
    input  logic             pd_slow,
    output logic             cke,
    output logic             ready,
    output logic [2:0]       pwr_mode,
    input  logic [2:0]       res_sel,
    output logic [CNT_W-1:0] res_count
);

    pmode_t mode;

    pwr_state_fsm #(
        .ENTRY_CYC(ENTRY_CYC),
        .LAT_APD  (LAT_APD),
        .LAT_PPDF (LAT_PPDF),
        .LAT_PPDS (LAT_PPDS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pending(req_pending),
        .bank_open  (bank_open),
        .pd_slow    (pd_slow),
        .cke        (cke),
        .ready      (ready),
        .mode       (mode)
    );

    pwr_residency #(
        .CNT_W(CNT_W)
    ) u_res (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .sel  (res_sel),
        .count(res_count)
    );

    assign pwr_mode = mode;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode < 3'd5); // R8

endmodule

// File: tb/rank_pwr_ctrl_test.sv
module rank_pwr_ctrl_test;

    localparam int ENTRY_CYC = 2;
    localparam int LAT_APD   = 4;
    localparam int LAT_PPDF  = 4;
    localparam int LAT_PPDS  = 6;
    localparam int CNT_W     = 16;

    logic clk = 1'b0;
    logic rst_n, req_pending, bank_open, pd_slow;
    logic cke, ready;
    logic [2:0] pwr_mode, res_sel;
    logic [CNT_W-1:0] res_count;

    int checks = 0;
    int failures = 0;
    int tally [8];
    logic [2:0] pend_m;
    logic pend_v = 1'b0;

    always #10 clk = ~clk;

    rank_pwr_ctrl #(
        .ENTRY_CYC(ENTRY_CYC), .LAT_APD(LAT_APD), .LAT_PPDF(LAT_PPDF),
        .LAT_PPDS(LAT_PPDS), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_pending(req_pending),
        .bank_open(bank_open), .pd_slow(pd_slow), .cke(cke), .ready(ready),
        .pwr_mode(pwr_mode), .res_sel(res_sel), .res_count(res_count)
    );

    // Bench-side residency tally: mode seen before each counting edge.
    always @(negedge clk) begin
        pend_m <= pwr_mode;
        pend_v <= rst_n;
    end
    always @(posedge clk) begin
        #1;
        if (pend_v) tally[pend_m] = tally[pend_m] + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic run_case(input logic open, input logic slow, input logic hold);
        int exp_mode, lat, lo, ex;
        exp_mode = open ? 2 : (slow ? 4 : 3);
        lat = open ? LAT_APD : (slow ? LAT_PPDS : LAT_PPDF);
        drive_edge();
        bank_open = open; pd_slow = slow; req_pending = 1'b1;
        drive_edge();
        @(negedge clk);
        chk("R2 standby mode", pwr_mode, open ? 0 : 1);
        chk("R9 ready in standby", {30'd0, cke, ready}, 3);
        drive_edge();
        req_pending = 1'b0;
        drive_edge();
        if (hold) req_pending = 1'b1;
        @(negedge clk);
        chk("R3 cke/ready low on entry", {30'd0, cke, ready}, 0);
        chk("R4 chosen mode", pwr_mode, exp_mode);
        lo = 1;
        if (!hold) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R4 mode held in power-down", {28'd0, cke, pwr_mode}, exp_mode);
                lo++;
            end
            drive_edge();
            req_pending = 1'b1;
        end
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!cke) lo++;
            else break;
        end
        if (hold) chk("R5 entry length with held request", lo, ENTRY_CYC);
        chk("R6 exit starts with ready low", {31'd0, ready}, 0);
        ex = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!ready) ex++;
            else break;
        end
        chk("R6 exit latency", ex, lat);
        chk("R6 cke high with ready", {31'd0, cke}, 1);
        chk("R2 standby mode after exit", pwr_mode, open ? 0 : 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) tally[i] = 0;
        rst_n = 1'b0; req_pending = 1'b1; bank_open = 1'b0; pd_slow = 1'b0;
        res_sel = 3'd0;
        repeat (3) drive_edge();
        @(negedge clk);
        chk("R1 reset cke/ready", {30'd0, cke, ready}, 3);
        chk("R1 reset mode", pwr_mode, 1);
        for (int s = 0; s < 8; s++) begin
            res_sel = 3'(s);
            #1;
            chk("R1 reset counters", int'(res_count), 0);
        end
        drive_edge();
        rst_n = 1'b1;

        // R9: steady requests keep the rank in standby.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 stays ready", {30'd0, cke, ready}, 3);
        end

        for (int o = 0; o < 2; o++)
            for (int s = 0; s < 2; s++)
                for (int h = 0; h < 2; h++)
                    run_case(o[0], s[0], h[0]);

        // R7/R8: residency counters against the bench tally.
        @(negedge clk);
        #5;
        for (int s = 0; s < 8; s++) begin
            res_sel = 3'(s);
            #1;
            if (s == 7) chk("R7 unused code reads zero", int'(res_count), 0);
            else if (s >= 5) chk("R8 self-refresh counter zero", int'(res_count), 0);
            else chk("R7 residency count", int'(res_count), tally[s]);
        end
        chk("R8 self-refresh never reported", tally[5] + tally[6], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule